// File: doc/BRIEF.md
# Algorithmic Memory Test Pattern Generator

This block stands between a tester's per-cycle stimulus byte and the address or data pins of a memory under test. In this mode the stimulus byte does not carry a pin value. It carries a few control bits, and those bits steer an on-chip pattern engine.

The engine holds a 32-bit pattern register that drives the device and a 32-bit constant register. The constant register is filled four bits per strobe. A two-bit algorithm select decides how the pattern register moves on each strobe. The choices are:

- increment by the carry bit;
- shift left with a serial bit entering;
- toggle a checkerboard;
- copy the constant register.

The stimulus byte can ask for the result to be inverted before it is stored.

Beside the full pattern, the block presents an expected-response word. This word is the pattern cut down to the significant width of the instance: 15 bits for an address instance, 8 bits for a data instance. A comparator therefore checks the device against the generated pattern rather than against the raw stimulus byte.

Top module: `mtpg_top`

## Requirements
- R1: A synchronous reset clears the pattern register, the constant register and the checkerboard phase, so `pat_o` and `exp_o` read zero after reset.
- R2: A stimulus byte with bit 7 low is not a strobe. Whatever bits 6:0 and `alg_i` hold, neither the pattern register nor the constant register changes.
- R3: With `alg_i` = 0 (increment), a strobe stores the pattern plus stimulus bit 0. The sum wraps modulo 2^32, so 0xFFFFFFFF plus 1 gives 0.
- R4: With `alg_i` = 1 (shift), a strobe stores the pattern shifted left by one, with stimulus bit 0 entering bit 0.
- R5: With `alg_i` = 2 (checkerboard), the first such strobe after reset stores 0x55555555. Each further checkerboard strobe alternates with 0xAAAAAAAA. Strobes under other algorithms do not advance this phase.
- R6: With `alg_i` = 3 (copy), a strobe stores the constant register as it stood before that same strobe's nibble load.
- R7: Stimulus bit 1 high on a strobe inverts the computed result, bit by bit, before it is stored. This holds for every algorithm.
- R8: A strobe with stimulus bit 2 high shifts the constant register left by four and places stimulus bits 6:3 in its bits 3:0. Eight such strobes therefore replace all 32 bits.
- R9: `exp_o` equals `pat_o` with every bit at or above `SIG_W` forced to zero. With the default `SIG_W` = 15, that is `pat_o` & 0x7FFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; a strobe commits on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| stim_i | input | 8 | Stimulus byte: bit 0 carry/serial, bit 1 invert, bit 2 constant load, bits 6:3 nibble, bit 7 strobe |
| alg_i | input | 2 | Algorithm: 0 increment, 1 shift, 2 checkerboard, 3 copy constant |
| pat_o | output | WORD_W | Full pattern register |
| exp_o | output | WORD_W | Expected response: pattern masked to SIG_W bits |

## Verification
The constant register is first filled with a sequence of distinct nibbles. It is then copied out while a new nibble loads on the same strobe, which shows whether the copy takes the old or the new value and whether the nibble order is right. Increment is run with carry both set and clear, and across the all-ones wrap. Shift is fed a mixed serial bit stream so that a wrong entry bit or direction shows up. Idle bytes with busy low bits are placed between strobes; these, and the checkerboard runs after a reset (with inversion and with interleaved other algorithms), show whether anything moves without a strobe or whether the phase advances when it should not. Every result is also compared in masked form on `exp_o`.

// File: rtl/mtpg_pkg.sv
package mtpg_pkg;

    typedef enum logic [1:0] {
        ALG_INC = 2'd0,
        ALG_SHL = 2'd1,
        ALG_CHK = 2'd2,
        ALG_CPY = 2'd3
    } alg_e;

    localparam int NIB_W = 4;

    typedef struct packed {
        logic             strobe;
        logic [NIB_W-1:0] nib;
        logic             ld;
        logic             inv;
        logic             cin;
    } ctl_t;

endpackage

// File: rtl/mtpg_decode.sv
module mtpg_decode
    import mtpg_pkg::*;
(
    input  logic [7:0] stim_i,
    output ctl_t       ctl_o
);
    always_comb begin
        ctl_o.cin    = stim_i[0];
        ctl_o.inv    = stim_i[1];
        ctl_o.ld     = stim_i[2];
        ctl_o.nib    = stim_i[6:3];
        ctl_o.strobe = stim_i[7];
    end
endmodule

// File: rtl/mtpg_func.sv
module mtpg_func
    import mtpg_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  alg_e              alg_i,
    input  logic [WORD_W-1:0] cur_i,
    input  logic [WORD_W-1:0] cst_i,
    input  logic              ph_i,
    input  logic              cin_i,
    input  logic              inv_i,
    output logic [WORD_W-1:0] res_o
);
    logic [WORD_W-1:0] chk_even;
    logic [WORD_W-1:0] raw;

    // even bits set: 0x55 in every byte
    for (genvar i = 0; i < WORD_W; i++) begin : g_chk
        assign chk_even[i] = (i % 2 == 0);
    end

    always_comb begin
        unique case (alg_i)
            ALG_INC: raw = cur_i + WORD_W'(cin_i);
            ALG_SHL: raw = {cur_i[WORD_W-2:0], cin_i};
            ALG_CHK: raw = ph_i ? ~chk_even : chk_even;
            default: raw = cst_i;
        endcase
        res_o = inv_i ? ~raw : raw;
    end
endmodule

// File: rtl/mtpg_const.sv
module mtpg_const
    import mtpg_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  ctl_t              ctl_i,
    output logic [WORD_W-1:0] cst_o
);
    logic [WORD_W-1:0] cst_d, cst_q;

    always_comb begin
        cst_d = cst_q;
        if (ctl_i.strobe && ctl_i.ld) begin
            cst_d = {cst_q[WORD_W-NIB_W-1:0], ctl_i.nib};
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cst_q <= '0;
        else       cst_q <= cst_d;
    end

    assign cst_o = cst_q;

    // R8: nibble enters at the bottom, old content moves up
    p_nib_load_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctl_i.strobe && ctl_i.ld) |=>
            (cst_q[NIB_W-1:0] == $past(ctl_i.nib)) &&
            (cst_q[WORD_W-1:NIB_W] == $past(cst_q[WORD_W-NIB_W-1:0])));

    // R2: no strobe, no change
    p_cst_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !ctl_i.strobe |=> $stable(cst_q));
endmodule

// File: rtl/mtpg_top.sv
module mtpg_top
    import mtpg_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int SIG_W  = 15
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [7:0]        stim_i,
    input  logic [1:0]        alg_i,
    output logic [WORD_W-1:0] pat_o,
    output logic [WORD_W-1:0] exp_o
);
    typedef struct packed {
        logic [WORD_W-1:0] pat;
        logic              ph;
    } state_t;

    localparam logic [WORD_W-1:0] CHK_LO = {(WORD_W/2){2'b01}};

    ctl_t              ctl;
    alg_e              alg;
    logic [WORD_W-1:0] cst;
    logic [WORD_W-1:0] res;
    logic [WORD_W-1:0] sig_mask;
    state_t            st_d, st_q;

    assign alg = alg_e'(alg_i);

    mtpg_decode i_decode (
        .stim_i (stim_i),
        .ctl_o  (ctl)
    );

    mtpg_const #(.WORD_W(WORD_W)) i_const (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .ctl_i (ctl),
        .cst_o (cst)
    );

    mtpg_func #(.WORD_W(WORD_W)) i_func (
        .alg_i (alg),
        .cur_i (st_q.pat),
        .cst_i (cst),
        .ph_i  (st_q.ph),
        .cin_i (ctl.cin),
        .inv_i (ctl.inv),
        .res_o (res)
    );

    for (genvar i = 0; i < WORD_W; i++) begin : g_mask
        assign sig_mask[i] = (i < SIG_W);
    end

    always_comb begin
        st_d = st_q;
        if (ctl.strobe) begin
            st_d.pat = res;
            if (alg == ALG_CHK) st_d.ph = ~st_q.ph;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign pat_o = st_q.pat;
    assign exp_o = st_q.pat & sig_mask;

    // R2: pattern holds without a strobe
    p_pat_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !ctl.strobe |=> $stable(st_q.pat));

    // R3: increment adds the carry bit
    p_inc_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctl.strobe && alg == ALG_INC && !ctl.inv) |=>
            st_q.pat == $past(st_q.pat) + WORD_W'($past(ctl.cin)));

    // R4: shift moves left, serial bit enters at bit 0
    p_shl_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctl.strobe && alg == ALG_SHL && !ctl.inv) |=>
            st_q.pat == {$past(st_q.pat[WORD_W-2:0]), $past(ctl.cin)});

    // R5: checkerboard result is one of the two alternating words
    p_chk_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctl.strobe && alg == ALG_CHK) |=>
            (st_q.pat == CHK_LO) || (st_q.pat == ~CHK_LO));

    // R6 and R7: inverted copy takes the constant from before the strobe
    p_cpy_inv_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctl.strobe && alg == ALG_CPY && ctl.inv) |=>
            st_q.pat == ~$past(cst));
endmodule

// File: tb/test_mtpg_top.sv
module test_mtpg_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  stim = 8'h00;
    logic [1:0]  alg = 2'd0;
    logic [31:0] pat, expd;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [31:0] q_pat[$];
    string       q_req[$];

    logic [31:0] m_pat = 32'h0;
    logic [31:0] m_cst = 32'h0;
    logic        m_ph  = 1'b0;

    always #5 clk = ~clk;

    mtpg_top i_mtpg_top (
        .clk_i  (clk),
        .rst_i  (rst),
        .stim_i (stim),
        .alg_i  (alg),
        .pat_o  (pat),
        .exp_o  (expd)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exv);
        n_chk++;
        if (act !== exv) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exv);
        end
    endtask

    // driver: applies one byte and pushes the expected pattern
    task automatic drive(input logic s, input logic [3:0] nib, input logic ld,
                         input logic inv, input logic cin, input logic [1:0] a,
                         input string req);
        logic [31:0] r;
        @(negedge clk);
        stim = {s, nib, ld, inv, cin};
        alg  = a;
        if (s) begin
            case (a)
                2'd0: r = m_pat + {31'h0, cin};
                2'd1: r = {m_pat[30:0], cin};
                2'd2: r = m_ph ? 32'hAAAA_AAAA : 32'h5555_5555;
                default: r = m_cst;
            endcase
            if (inv) r = ~r;
            if (a == 2'd2) m_ph = ~m_ph;
            if (ld) m_cst = {m_cst[27:0], nib};
            m_pat = r;
        end
        q_pat.push_back(m_pat);
        q_req.push_back(req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        stim = 8'h00;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_pat = 32'h0; m_cst = 32'h0; m_ph = 1'b0;
        check("R1 pat", pat, 32'h0);
        check("R1 exp", expd, 32'h0);
    endtask

    // monitor: pops and compares after each rising edge
    always @(posedge clk) begin
        #1;
        if (q_pat.size() > 0) begin
            logic [31:0] e;
            string rq;
            e  = q_pat.pop_front();
            rq = q_req.pop_front();
            check(rq, pat, e);
            check({rq, " R9 exp"}, expd, e & 32'h0000_7FFF);
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 pat", pat, 32'h0);
        check("R1 exp", expd, 32'h0);

        // R8: fill constant with nibbles 1..8 (increment by zero keeps pattern)
        for (int k = 1; k <= 8; k++) drive(1, 4'(k), 1, 0, 0, 2'd0, "R8 fill");
        // R6: copy takes old constant while a new nibble loads
        drive(1, 4'hF, 1, 0, 0, 2'd3, "R6 copy old");
        drive(1, 4'h0, 0, 0, 0, 2'd3, "R8 shifted");
        // R2: idle bytes with busy low bits
        drive(0, 4'hA, 1, 1, 1, 2'd0, "R2 idle inc");
        drive(0, 4'h5, 1, 0, 1, 2'd2, "R2 idle chk");
        drive(0, 4'h3, 1, 1, 0, 2'd3, "R2 idle cpy");
        drive(1, 4'h0, 0, 0, 0, 2'd3, "R2 const kept");
        // R3: increment with carry set and clear
        drive(1, 4'h0, 0, 0, 1, 2'd0, "R3 inc c1");
        drive(1, 4'h0, 0, 0, 0, 2'd0, "R3 inc c0");
        drive(1, 4'h0, 0, 0, 1, 2'd0, "R3 inc c1");
        // R3: wrap from all ones
        for (int k = 0; k < 8; k++) drive(1, 4'hF, 1, 0, 0, 2'd0, "R8 fill ones");
        drive(1, 4'h0, 0, 0, 0, 2'd3, "R6 copy ones");
        drive(1, 4'h0, 0, 0, 1, 2'd0, "R3 wrap");
        // R7: inverted increment and inverted copy
        drive(1, 4'h0, 0, 1, 1, 2'd0, "R7 inv inc");
        drive(1, 4'h0, 0, 1, 0, 2'd3, "R7 inv copy");
        // R4: shift with a mixed serial stream
        drive(1, 4'h0, 0, 0, 1, 2'd1, "R4 shl 1");
        drive(1, 4'h0, 0, 0, 0, 2'd1, "R4 shl 0");
        drive(1, 4'h0, 0, 0, 1, 2'd1, "R4 shl 1");
        drive(1, 4'h0, 0, 0, 1, 2'd1, "R4 shl 1");
        drive(1, 4'h0, 0, 1, 0, 2'd1, "R7 inv shl");
        @(negedge clk);
        @(negedge clk);

        // R5: checkerboard after reset
        do_reset();
        drive(1, 4'h0, 0, 0, 0, 2'd2, "R5 first 55");
        drive(1, 4'h0, 0, 0, 0, 2'd2, "R5 then AA");
        drive(1, 4'h0, 0, 0, 1, 2'd0, "R3 inc between");
        drive(0, 4'h0, 0, 0, 0, 2'd2, "R2 idle chk");
        drive(1, 4'h0, 0, 0, 0, 2'd2, "R5 back 55");
        drive(1, 4'h0, 0, 1, 0, 2'd2, "R7 inv chk");
        drive(1, 4'h0, 0, 0, 0, 2'd2, "R5 phase 55");
        @(negedge clk);
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule